// File: doc/BRIEF.md
# Two-Resolution Path Feasibility Controller

This block decides whether a flight path, given as a chain of straight segments, clears the terrain. The path runs from the vehicle's present position through up to fourteen intermediate waypoints to a goal. The intermediate waypoints sit in a synchronous path memory. The vehicle position, the goal, the waypoint count and the memory base address arrive on ports and are latched when a check is launched. The controller works through the segments in order and hands each one to an external line walker. The walker reports the cells the segment crosses, one cell per cycle. For each cell it gives the path altitude and the terrain altitude at that cell.

Two height maps serve the walker. The first two segments, the ones closest to the vehicle, are walked over the full-resolution map. Every later segment is walked over a coarse map. Each coarse cell holds the highest terrain of a 16×16 block of fine cells. For those later segments the controller gives the endpoint coordinates already reduced to coarse-map indices. The controller compares every reported cell itself. It stops at the first cell whose terrain reaches the path. It then raises either a collision flag or a completion flag, and that flag stays up until the next launch.

Top module: `terrain_path_checker`

## Requirements
- R1: While reset is held and just after it is released, `hit_flag`, `pass_flag`, `seg_go` and `pm_rd` are all 0.
- R2: A `chk_en` sampled high while no check is running latches the vehicle position, goal, `wpt_num` and `path_base`. It also clears both flags, so both read 0 in the cycle that follows.
- R3: The path points are, in order: the vehicle position, then `path_base+0` up to `path_base+N-1` read from path memory, then the goal. Here N is `wpt_num`, clamped to 14 when the input is larger. A check issues N+1 segments, and segment k runs from point k to point k+1. On the final segment no memory read is made.
- R4: Segments 0 and 1 are issued with `seg_coarse`=0 and full fine-map coordinates. Segments 2 and up are issued with `seg_coarse`=1, with X and Y shifted right by 4 bits and the altitudes unchanged.
- R5: A reported cell is a collision when `cell_path_z` <= `cell_terr_z`, so equal altitudes count as a collision. On the first collision `hit_flag` is 1 in the next cycle, the check ends, and no further segment is issued.
- R6: When the cell flagged `cell_last` of the final segment is free of collision, `pass_flag` is 1 in the next cycle and the check ends.
- R7: The two flags are never 1 at the same time. If a collision falls on the last cell of the last segment, only `hit_flag` rises.
- R8: After a check ends, both flags keep their values and no `seg_go` appears until the next launch.
- R9: A `chk_en` that arrives while a check is running has no effect. The segments issued and the result are the same as without it.
- R10: `seg_go` is a one-cycle pulse, one per segment. It is high in the third cycle after the cycle in which the launch is sampled, and likewise in the third cycle after the cycle in which a segment's last cell is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Launch request, sampled only when idle |
| wpt_num | input | 4 | Number of intermediate waypoints (clamped to 14) |
| path_base | input | 8 | Path memory address of the first intermediate waypoint |
| uav_x | input | 9 | Vehicle X cell index |
| uav_y | input | 9 | Vehicle Y cell index |
| uav_z | input | 12 | Vehicle altitude |
| goal_x | input | 9 | Goal X cell index |
| goal_y | input | 9 | Goal Y cell index |
| goal_z | input | 12 | Goal altitude |
| pm_rd | output | 1 | Path memory read strobe |
| pm_addr | output | 8 | Path memory read address |
| pm_x | input | 9 | Waypoint X, valid the cycle after the read |
| pm_y | input | 9 | Waypoint Y, valid the cycle after the read |
| pm_z | input | 12 | Waypoint altitude, valid the cycle after the read |
| seg_go | output | 1 | Segment start pulse to the line walker |
| seg_coarse | output | 1 | 1 when the segment is to be walked over the coarse map |
| seg_ax | output | 9 | Segment start X, in the selected map's indices |
| seg_ay | output | 9 | Segment start Y, in the selected map's indices |
| seg_az | output | 12 | Segment start altitude |
| seg_bx | output | 9 | Segment end X, in the selected map's indices |
| seg_by | output | 9 | Segment end Y, in the selected map's indices |
| seg_bz | output | 12 | Segment end altitude |
| cell_vld | input | 1 | Walker reports one cell this cycle |
| cell_last | input | 1 | The reported cell is the segment's final cell |
| cell_path_z | input | 12 | Path altitude over the reported cell |
| cell_terr_z | input | 12 | Terrain altitude of the reported cell |
| hit_flag | output | 1 | Collision found; held until the next launch |
| pass_flag | output | 1 | Whole path clear; held until the next launch |

## Verification
Collision detection and completion meet when the cell that ends the final segment is also the one whose terrain reaches the path. The bench arranges this by reporting the last cell of the last segment with a terrain altitude above the path altitude. It then requires that only `hit_flag` rises. A second case puts the terrain exactly equal to the path on an inner cell, which tests the boundary of the comparison. The launch and the segment handoff can also coincide. The bench pulses `chk_en` while the first cell of the first segment is being reported. It then requires the segment endpoints, the segment count and the final flag to be the same as in an undisturbed run.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    // Fine-map index width (512 cells per side), altitude width
    parameter int XY_W     = 9;
    parameter int Z_W      = 12;
    // Coarse cell covers 2**POOL_SH fine cells per side
    parameter int POOL_SH  = 4;
    // Path points including start and goal
    parameter int MAX_PTS  = 16;
    // Segments walked over the fine map
    parameter int FINE_SEGS = 2;

    localparam int MAX_MID = MAX_PTS - 2;
    localparam int CNT_W   = $clog2(MAX_PTS);

    typedef struct packed {
        logic [XY_W-1:0] x;
        logic [XY_W-1:0] y;
        logic [Z_W-1:0]  z;
    } point_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FINE   = 2'd1,
        ST_COARSE = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_LOAD  = 2'd1,
        PH_ISSUE = 2'd2,
        PH_WALK  = 2'd3
    } phase_e;

    // Fine-map point to coarse-map point: drop the low index bits
    function automatic point_t to_coarse(input point_t p);
        point_t r;
        r   = p;
        r.x = p.x >> POOL_SH;
        r.y = p.y >> POOL_SH;
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] clamp_mid(input logic [CNT_W-1:0] req);
        if (int'(req) > MAX_MID)
            return CNT_W'(MAX_MID);
        return req;
    endfunction

endpackage

// File: rtl/tpc_cell_cmp.sv
module tpc_cell_cmp #(
    parameter int ALT_W = 12
) (
    input  logic [ALT_W-1:0] path_alt,
    input  logic [ALT_W-1:0] terr_alt,
    output logic             blocked
);
    // Terrain touching or above the path is a collision
    assign blocked = (path_alt <= terr_alt);
endmodule

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
    import tpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_en,
    input  logic [CNT_W-1:0] mid_req,
    input  logic             cell_vld,
    input  logic             cell_last,
    input  logic             cell_blocked,
    output mode_e            mode,
    output phase_e           phase,
    output logic [CNT_W-1:0] seg_idx,
    output logic [CNT_W-1:0] mid_num,
    output logic             capture,
    output logic             advance,
    output logic             hit_flag,
    output logic             pass_flag
);
    logic             cell_take;
    logic             last_seg;
    logic [CNT_W-1:0] next_idx;

    assign capture   = (mode == ST_IDLE) && chk_en;
    assign cell_take = (mode != ST_IDLE) && (phase == PH_WALK) && cell_vld;
    assign last_seg  = (seg_idx == mid_num);
    assign next_idx  = seg_idx + CNT_W'(1);
    assign advance   = cell_take && !cell_blocked && cell_last && !last_seg;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= ST_IDLE;
            phase     <= PH_FETCH;
            seg_idx   <= '0;
            mid_num   <= '0;
            hit_flag  <= 1'b0;
            pass_flag <= 1'b0;
        end else if (capture) begin
            mode      <= ST_FINE;
            phase     <= PH_FETCH;
            seg_idx   <= '0;
            mid_num   <= clamp_mid(mid_req);
            hit_flag  <= 1'b0;
            pass_flag <= 1'b0;
        end else if (mode != ST_IDLE) begin
            case (phase)
                PH_FETCH: phase <= PH_LOAD;
                PH_LOAD:  phase <= PH_ISSUE;
                PH_ISSUE: phase <= PH_WALK;
                default: begin
                    if (cell_take) begin
                        if (cell_blocked) begin
                            hit_flag <= 1'b1;
                            mode     <= ST_IDLE;
                            phase    <= PH_FETCH;
                        end else if (cell_last) begin
                            if (last_seg) begin
                                pass_flag <= 1'b1;
                                mode      <= ST_IDLE;
                                phase     <= PH_FETCH;
                            end else begin
                                seg_idx <= next_idx;
                                phase   <= PH_FETCH;
                                mode    <= (int'(next_idx) >= FINE_SEGS) ? ST_COARSE : ST_FINE;
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tpc_points.sv
module tpc_points
    import tpc_pkg::*;
#(
    parameter int PA_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             advance,
    input  mode_e            mode,
    input  phase_e           phase,
    input  logic [CNT_W-1:0] seg_idx,
    input  logic [CNT_W-1:0] mid_num,
    input  point_t           start_pt,
    input  point_t           goal_pt,
    input  logic [PA_W-1:0]  base_in,
    input  point_t           mem_pt,
    output logic             rd_en,
    output logic [PA_W-1:0]  rd_addr,
    output logic             coarse,
    output point_t           seg_a,
    output point_t           seg_b
);
    point_t          pt_a;
    point_t          pt_b;
    point_t          pt_goal;
    logic [PA_W-1:0] base_q;
    logic            from_mem;
    logic            active;

    assign active   = (mode != ST_IDLE);
    assign from_mem = (seg_idx < mid_num);
    assign rd_en    = active && (phase == PH_FETCH) && from_mem;
    assign rd_addr  = base_q + PA_W'(seg_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_a    <= '0;
            pt_b    <= '0;
            pt_goal <= '0;
            base_q  <= '0;
        end else begin
            if (capture) begin
                pt_a    <= start_pt;
                pt_goal <= goal_pt;
                base_q  <= base_in;
            end else if (advance) begin
                pt_a <= pt_b;
            end
            if (active && (phase == PH_LOAD))
                pt_b <= from_mem ? mem_pt : pt_goal;
        end
    end

    assign coarse = (mode == ST_COARSE);
    assign seg_a  = coarse ? to_coarse(pt_a) : pt_a;
    assign seg_b  = coarse ? to_coarse(pt_b) : pt_b;
endmodule

// File: rtl/terrain_path_checker.sv
module terrain_path_checker
    import tpc_pkg::*;
#(
    parameter int PA_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_en,
    input  logic [CNT_W-1:0] wpt_num,
    input  logic [PA_W-1:0]  path_base,
    input  logic [XY_W-1:0]  uav_x,
    input  logic [XY_W-1:0]  uav_y,
    input  logic [Z_W-1:0]   uav_z,
    input  logic [XY_W-1:0]  goal_x,
    input  logic [XY_W-1:0]  goal_y,
    input  logic [Z_W-1:0]   goal_z,
    output logic             pm_rd,
    output logic [PA_W-1:0]  pm_addr,
    input  logic [XY_W-1:0]  pm_x,
    input  logic [XY_W-1:0]  pm_y,
    input  logic [Z_W-1:0]   pm_z,
    output logic             seg_go,
    output logic             seg_coarse,
    output logic [XY_W-1:0]  seg_ax,
    output logic [XY_W-1:0]  seg_ay,
    output logic [Z_W-1:0]   seg_az,
    output logic [XY_W-1:0]  seg_bx,
    output logic [XY_W-1:0]  seg_by,
    output logic [Z_W-1:0]   seg_bz,
    input  logic             cell_vld,
    input  logic             cell_last,
    input  logic [Z_W-1:0]   cell_path_z,
    input  logic [Z_W-1:0]   cell_terr_z,
    output logic             hit_flag,
    output logic             pass_flag
);
    mode_e            mode;
    phase_e           phase;
    logic [CNT_W-1:0] seg_idx;
    logic [CNT_W-1:0] mid_num;
    logic             capture;
    logic             advance;
    logic             blocked;
    logic             running;
    point_t           start_pt;
    point_t           goal_pt;
    point_t           mem_pt;
    point_t           seg_a;
    point_t           seg_b;

    assign start_pt = {uav_x, uav_y, uav_z};
    assign goal_pt  = {goal_x, goal_y, goal_z};
    assign mem_pt   = {pm_x, pm_y, pm_z};
    assign running  = (mode != ST_IDLE);
    assign seg_go   = running && (phase == PH_ISSUE);

    tpc_cell_cmp #(.ALT_W(Z_W)) u_cmp (
        .path_alt (cell_path_z),
        .terr_alt (cell_terr_z),
        .blocked  (blocked)
    );

    tpc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .chk_en       (chk_en),
        .mid_req      (wpt_num),
        .cell_vld     (cell_vld),
        .cell_last    (cell_last),
        .cell_blocked (blocked),
        .mode         (mode),
        .phase        (phase),
        .seg_idx      (seg_idx),
        .mid_num      (mid_num),
        .capture      (capture),
        .advance      (advance),
        .hit_flag     (hit_flag),
        .pass_flag    (pass_flag)
    );

    tpc_points #(.PA_W(PA_W)) u_pts (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .advance  (advance),
        .mode     (mode),
        .phase    (phase),
        .seg_idx  (seg_idx),
        .mid_num  (mid_num),
        .start_pt (start_pt),
        .goal_pt  (goal_pt),
        .base_in  (path_base),
        .mem_pt   (mem_pt),
        .rd_en    (pm_rd),
        .rd_addr  (pm_addr),
        .coarse   (seg_coarse),
        .seg_a    (seg_a),
        .seg_b    (seg_b)
    );

    assign seg_ax = seg_a.x;
    assign seg_ay = seg_a.y;
    assign seg_az = seg_a.z;
    assign seg_bx = seg_b.x;
    assign seg_by = seg_b.y;
    assign seg_bz = seg_b.z;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter int ALT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             chk_en,
    input logic             running,
    input logic             seg_go,
    input logic             cell_vld,
    input logic             cell_last,
    input logic [ALT_W-1:0] cell_path_z,
    input logic [ALT_W-1:0] cell_terr_z,
    input logic             hit_flag,
    input logic             pass_flag
);
    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit_flag && pass_flag));

    // R5
    hit_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hit_flag) |-> $past(cell_vld && (cell_path_z <= cell_terr_z)));

    // R6
    pass_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pass_flag) |-> $past(cell_vld && cell_last && (cell_path_z > cell_terr_z)));

    // R2
    launch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && chk_en) |=> (running && !hit_flag && !pass_flag));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !chk_en) |=> ($stable(hit_flag) && $stable(pass_flag)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> !seg_go);

    // R10
    go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        seg_go |=> !seg_go);
endmodule

bind terrain_path_checker tpc_checker #(.ALT_W(tpc_pkg::Z_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chk_en      (chk_en),
    .running     (running),
    .seg_go      (seg_go),
    .cell_vld    (cell_vld),
    .cell_last   (cell_last),
    .cell_path_z (cell_path_z),
    .cell_terr_z (cell_terr_z),
    .hit_flag    (hit_flag),
    .pass_flag   (pass_flag)
);

// File: tb/sim_terrain_path_checker.sv
module sim_terrain_path_checker;
    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_en = 1'b0;
    logic [3:0]  wpt_num = '0;
    logic [7:0]  path_base = '0;
    logic [8:0]  uav_x = '0, uav_y = '0, goal_x = '0, goal_y = '0;
    logic [11:0] uav_z = '0, goal_z = '0;
    logic        pm_rd;
    logic [7:0]  pm_addr;
    logic [8:0]  pm_x = '0, pm_y = '0;
    logic [11:0] pm_z = '0;
    logic        seg_go, seg_coarse;
    logic [8:0]  seg_ax, seg_ay, seg_bx, seg_by;
    logic [11:0] seg_az, seg_bz;
    logic        cell_vld = 1'b0, cell_last = 1'b0;
    logic [11:0] cell_path_z = '0, cell_terr_z = '0;
    logic        hit_flag, pass_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int mem_x[256];
    int mem_y[256];
    int mem_z[256];

    always #(PERIOD/2) clk = ~clk;

    // Synchronous path memory model
    always @(posedge clk) begin
        if (pm_rd) begin
            pm_x <= 9'(mem_x[pm_addr]);
            pm_y <= 9'(mem_y[pm_addr]);
            pm_z <= 12'(mem_z[pm_addr]);
        end
    end

    terrain_path_checker u0 (
        .clk(clk), .rst(rst), .chk_en(chk_en), .wpt_num(wpt_num), .path_base(path_base),
        .uav_x(uav_x), .uav_y(uav_y), .uav_z(uav_z),
        .goal_x(goal_x), .goal_y(goal_y), .goal_z(goal_z),
        .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_x(pm_x), .pm_y(pm_y), .pm_z(pm_z),
        .seg_go(seg_go), .seg_coarse(seg_coarse),
        .seg_ax(seg_ax), .seg_ay(seg_ay), .seg_az(seg_az),
        .seg_bx(seg_bx), .seg_by(seg_by), .seg_bz(seg_bz),
        .cell_vld(cell_vld), .cell_last(cell_last),
        .cell_path_z(cell_path_z), .cell_terr_z(cell_terr_z),
        .hit_flag(hit_flag), .pass_flag(pass_flag)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One launch; the walker model answers every seg_go with 2 + k%3 cells
    task automatic run_path(input string name, input int n_in, input int base,
                            input int hit_s, input int hit_c, input bit eq_hit, input bit poke);
        int n_eff, segs_exp, seg, gap, guard, len;
        int ax, ay, bx, by;
        bit done, hit_now, exp_hit, ok, cx;
        bit h0, p0, held;
        int ex_x[17];
        int ex_y[17];
        int ex_z[17];
        $display("scenario %s", name);
        uav_x = 9'd40;   uav_y = 9'd470; uav_z = 12'd500;
        goal_x = 9'd300; goal_y = 9'd17; goal_z = 12'd800;
        n_eff    = (n_in > 14) ? 14 : n_in;
        exp_hit  = (hit_s >= 0);
        segs_exp = exp_hit ? hit_s + 1 : n_eff + 1;
        ex_x[0] = 40; ex_y[0] = 470; ex_z[0] = 500;
        for (int i = 1; i <= n_eff; i++) begin
            ex_x[i] = mem_x[base+i-1];
            ex_y[i] = mem_y[base+i-1];
            ex_z[i] = mem_z[base+i-1];
        end
        ex_x[n_eff+1] = 300; ex_y[n_eff+1] = 17; ex_z[n_eff+1] = 800;
        wpt_num   = 4'(n_in);
        path_base = 8'(base);
        @(negedge clk); chk_en = 1'b1;
        @(negedge clk); chk_en = 1'b0;
        // R2: flags cleared one cycle after launch
        chk(!hit_flag && !pass_flag, "R2", "flags after launch", int'({hit_flag, pass_flag}), 0);
        gap = 1; seg = 0; done = 0; guard = 0;
        while (!done && guard < 4000) begin
            @(negedge clk); gap++; guard++;
            if (seg_go) begin
                // R10: handoff latency
                chk(gap == 3, "R10", "cycles to seg_go", gap, 3);
                if (seg < segs_exp) begin
                    cx = (seg >= 2);
                    ax = cx ? ex_x[seg] >> 4 : ex_x[seg];
                    ay = cx ? ex_y[seg] >> 4 : ex_y[seg];
                    bx = cx ? ex_x[seg+1] >> 4 : ex_x[seg+1];
                    by = cx ? ex_y[seg+1] >> 4 : ex_y[seg+1];
                    ok = (seg_coarse == cx) && (seg_ax == ax) && (seg_ay == ay) &&
                         (seg_az == ex_z[seg]) && (seg_bx == bx) && (seg_by == by) &&
                         (seg_bz == ex_z[seg+1]);
                    // R3 endpoints, R4 map selection and index reduction
                    chk(ok, cx ? "R4" : "R3", $sformatf("segment %0d start x", seg), int'(seg_ax), ax);
                    chk(ok, cx ? "R4" : "R3", $sformatf("segment %0d end x", seg), int'(seg_bx), bx);
                end else begin
                    chk(0, "R3", "extra segment issued", seg, segs_exp);
                end
                len = 2 + seg % 3;
                hit_now = 0;
                for (int c = 0; c < len; c++) begin
                    @(negedge clk);
                    cell_vld    = 1'b1;
                    cell_last   = (c == len - 1);
                    cell_path_z = 12'd1000;
                    if (seg == hit_s && c == hit_c) begin
                        cell_terr_z = eq_hit ? 12'd1000 : 12'd1600;
                        hit_now = 1;
                    end else begin
                        cell_terr_z = 12'd999;
                    end
                    chk_en = poke && (seg == 0) && (c == 0);
                    if (chk_en) uav_x = 9'd123;
                    if (hit_now) break;
                end
                @(negedge clk);
                cell_vld = 1'b0; cell_last = 1'b0; chk_en = 1'b0;
                seg++; gap = 1;
                if (hit_now || seg == n_eff + 1) done = 1;
            end
        end
        chk(done, "R10", "segment handoff stalled", guard, 0);
        if (exp_hit)
            // R5 collision ends the check, R7 flags exclusive
            chk(hit_flag && !pass_flag, "R7", "flags after collision", int'({hit_flag, pass_flag}), 2);
        else
            // R6 completion
            chk(pass_flag && !hit_flag, "R6", "flags after clear path", int'({hit_flag, pass_flag}), 1);
        chk(seg == segs_exp, poke ? "R9" : "R5", "segments issued", seg, segs_exp);
        // R8: flags hold, no activity while idle
        h0 = hit_flag; p0 = pass_flag; held = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (seg_go || hit_flag != h0 || pass_flag != p0) held = 0;
        end
        chk(held, "R8", "flags hold after end", int'({hit_flag, pass_flag}), int'({h0, p0}));
    endtask

    task automatic t_reset;
        // R1
        chk(!hit_flag && !pass_flag && !seg_go && !pm_rd, "R1", "outputs after reset",
            int'({hit_flag, pass_flag, seg_go, pm_rd}), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_x[i] = (i * 37 + 11) % 512;
            mem_y[i] = (i * 53 + 200) % 512;
            mem_z[i] = i * 5 + 300;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_path("single segment",        0,   0, -1, 0, 0, 0);
        run_path("two fine segments",     1,   5, -1, 0, 0, 0);
        run_path("fine then coarse",      3,  20, -1, 0, 0, 0);
        run_path("equal altitude hit",    3,  30,  1, 2, 1, 0);   // R5
        run_path("coarse segment hit",    4,  40,  3, 0, 0, 0);   // R4 R5
        run_path("hit on final cell",     2,  50,  2, 3, 0, 0);   // R7
        run_path("count clamped",        15, 100, -1, 0, 0, 0);   // R3
        run_path("launch while running",  2,  60, -1, 0, 0, 1);   // R9
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule